// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block puts a bank of 256 byte-wide configuration registers behind two consecutive addresses of a byte-wide I/O bus. A write to the lower address loads an index pointer. A write to the upper address stores a byte into the register the pointer selects, but only when the protection policy for that index allows it. A read at either address returns the selected register. Each decoded access is acknowledged by a one-cycle strobe, and the read data arrives with that strobe.

A host configuration write port controls whether the window decodes at all. A host write to the enable offset opens the window when the enable bit is 1 and closes it when the bit is 0. The window is closed after reset. While it is closed, the block ignores bus accesses completely. Only the upper 32 indices (0xE0 to 0xFF) hold storage. Every index below 0xE0 is read-only and reads as zero.

The window is a two-state machine. **WIN_CLOSED** is the reset state. It moves to **WIN_OPEN** on the transition *open*: a host write to the enable offset with the enable bit set. **WIN_OPEN** returns to **WIN_CLOSED** on the transition *close*: a host write to the enable offset with the enable bit clear. Any other cycle *holds* the current state. The state takes effect one cycle after the host write, so a bus access in the same cycle as that write is decoded under the old state.

Top module: `idxcfg_port`

## Requirements
- R1: After reset the window is closed, `io_ack` is 0, `io_rdata` is 0xFF and the index is 0x00. The register defaults are 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE, and every other index is 0x00.
- R2: A host write (`cfg_wr`=1) to offset 0x85 opens the window from the next cycle when bit 1 of `cfg_wdata` is 1, and closes it from the next cycle when that bit is 0. Host writes to any other offset leave the window as it is.
- R3: While the window is closed, a bus access produces no `io_ack`, `io_rdata` stays 0xFF, and neither the index nor any register changes.
- R4: With the window open, a write to address 0x03F0 loads the index with the written byte, whatever its value. `io_ack` is 1 in the following cycle.
- R5: With the window open, a read at 0x03F0 or 0x03F1 returns the register at the current index on `io_rdata` in the following cycle, with `io_ack`=1. In any cycle without `io_ack`, `io_rdata` is 0xFF. A write to 0x03F1 is also acknowledged in the following cycle.
- R6: A data write to 0x03F1 leaves the register unchanged when the index is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R7: Index 0xE7 stores a data write only when the byte is 0xFE, and index 0xE8 only when the byte is 0xBE. Any other byte leaves the register unchanged.
- R8: Indices 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC store any byte written to 0x03F1.
- R9: A bus access to any address other than 0x03F0 or 0x03F1 gets no `io_ack` and changes neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Host configuration write strobe |
| cfg_off | input | 8 | Host configuration byte offset |
| cfg_wdata | input | 8 | Host configuration write byte; bit 1 is the window enable |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | I/O bus write strobe, one cycle per byte |
| io_rd | input | 1 | I/O bus read strobe, one cycle per byte |
| io_wdata | input | 8 | I/O bus write byte |
| io_rdata | output | 8 | Read byte, valid with `io_ack`, 0xFF otherwise |
| io_ack | output | 1 | Response strobe, one cycle after a decoded access |

## Verification
The assertions take for granted that a bus cycle carries at most one access, so `io_rd` and `io_wr` are never high together. One property states this assumption. Because the input is checked, a bench that breaks the rule shows up immediately. The stimulus drives every access through a single task that raises exactly one strobe for one cycle and clears it before the next access. The bench changes the enable only through whole host writes, between bus accesses, so no access falls in the cycle where the window state changes.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

    // indices that accept any byte
    function automatic logic idx_free(input byte_t idx);
        logic ok;
        case (idx) inside
            [8'hE0:8'hE3], 8'hE6, [8'hEE:8'hF2],
            8'hF4, 8'hF6, 8'hF8, 8'hFC: ok = 1'b1;
            default:                    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // full write policy: free indices plus the two value-locked ones
    function automatic logic write_permit(input byte_t idx, input byte_t data);
        logic ok;
        if (idx == 8'hE7)
            ok = (data == 8'hFE);
        else if (idx == 8'hE8)
            ok = (data == 8'hBE);
        else
            ok = idx_free(idx);
        return ok;
    endfunction

    function automatic byte_t reset_value(input byte_t idx);
        byte_t v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/idxcfg_gate.sv
module idxcfg_gate
    import idxcfg_pkg::*;
#(
    parameter int               CFG_OFF_W = 8,
    parameter logic [CFG_OFF_W-1:0] EN_OFFSET = 8'h85
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic                 en_bit,
    output logic                 win_on
);

    win_state_t state_q, state_d;
    logic       en_hit;

    assign en_hit = cfg_wr && (cfg_off == EN_OFFSET);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WIN_CLOSED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: if (en_hit && en_bit)  state_d = WIN_OPEN;
            WIN_OPEN:   if (en_hit && !en_bit) state_d = WIN_CLOSED;
            default:    state_d = WIN_CLOSED;
        endcase
    end

    always_comb begin
        win_on = (state_q == WIN_OPEN);
    end

endmodule

// File: rtl/idxcfg_policy.sv
module idxcfg_policy
    import idxcfg_pkg::*;
(
    input  byte_t idx,
    input  byte_t wdata,
    output logic  wr_ok
);

    assign wr_ok = write_permit(idx, wdata);

endmodule

// File: rtl/idxcfg_bank.sv
module idxcfg_bank
    import idxcfg_pkg::*;
#(
    parameter byte_t STORE_BASE = 8'hE0,
    parameter int    STORE_N    = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  byte_t idx,
    input  byte_t wdata,
    output byte_t rdata
);

    localparam int STORE_END = int'(STORE_BASE) + STORE_N;

    logic [STORE_N-1:0][7:0] cells;
    logic                    in_range;
    int                      slot;

    always_comb begin
        in_range = (int'(idx) >= int'(STORE_BASE)) && (int'(idx) < STORE_END);
        slot     = int'(idx) - int'(STORE_BASE);
    end

    for (genvar i = 0; i < STORE_N; i++) begin : g_cell
        localparam byte_t CELL_IDX = byte_t'(int'(STORE_BASE) + i);
        byte_t cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= reset_value(CELL_IDX);
            else if (we && in_range && (slot == i))
                cell_q <= wdata;
        end
        assign cells[i] = cell_q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < STORE_N; k++)
            if (in_range && (slot == k))
                rdata = cells[k];
    end

endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
    import idxcfg_pkg::*;
#(
    parameter int                   IO_ADDR_W  = 16,
    parameter logic [IO_ADDR_W-1:0] WIN_BASE   = 16'h03F0,
    parameter int                   CFG_OFF_W  = 8,
    parameter logic [CFG_OFF_W-1:0] EN_OFFSET  = 8'h85,
    parameter int                   EN_BIT     = 1,
    parameter byte_t                STORE_BASE = 8'hE0,
    parameter int                   STORE_N    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_OFF_W-1:0] cfg_off,
    input  logic [7:0]           cfg_wdata,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 io_ack
);

    localparam logic [IO_ADDR_W-1:0] DATA_ADDR = WIN_BASE + IO_ADDR_W'(1);

    logic  win_on;
    logic  hit_idx, hit_dat, rd_go, wr_go;
    logic  wr_ok, bank_we;
    byte_t idx_q, bank_rdata, rdata_q;
    logic  ack_q;

    idxcfg_gate #(
        .CFG_OFF_W (CFG_OFF_W),
        .EN_OFFSET (EN_OFFSET)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_off (cfg_off),
        .en_bit  (cfg_wdata[EN_BIT]),
        .win_on  (win_on)
    );

    always_comb begin
        hit_idx = (io_addr == WIN_BASE);
        hit_dat = (io_addr == DATA_ADDR);
        rd_go   = win_on && io_rd && (hit_idx || hit_dat);
        wr_go   = win_on && io_wr && (hit_idx || hit_dat);
    end

    idxcfg_policy u_policy (
        .idx   (idx_q),
        .wdata (io_wdata),
        .wr_ok (wr_ok)
    );

    assign bank_we = wr_go && hit_dat && wr_ok;

    idxcfg_bank #(
        .STORE_BASE (STORE_BASE),
        .STORE_N    (STORE_N)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .idx   (idx_q),
        .wdata (io_wdata),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= 8'h00;
        else if (wr_go && hit_idx)
            idx_q <= io_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= 8'hFF;
        end else begin
            ack_q   <= rd_go || wr_go;
            rdata_q <= rd_go ? bank_rdata : 8'hFF;
        end
    end

    assign io_ack   = ack_q;
    assign io_rdata = rdata_q;

endmodule

// File: rtl/idxcfg_port_chk.sv
module idxcfg_port_chk #(
    parameter int                   IO_ADDR_W = 16,
    parameter logic [IO_ADDR_W-1:0] WIN_BASE  = 16'h03F0,
    parameter int                   CFG_OFF_W = 8,
    parameter logic [CFG_OFF_W-1:0] EN_OFFSET = 8'h85
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic [CFG_OFF_W-1:0] cfg_off,
    input logic                 en_bit,
    input logic [IO_ADDR_W-1:0] io_addr,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 io_ack,
    input logic                 win_on,
    input logic [7:0]           idx_q
);

    localparam logic [IO_ADDR_W-1:0] DATA_ADDR = WIN_BASE + IO_ADDR_W'(1);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr)); // R5

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_off == EN_OFFSET) |=> (win_on == $past(en_bit))); // R2

    AST_CLOSED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_on && (io_rd || io_wr)) |=> !io_ack); // R3

    AST_CLOSED_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_on |=> $stable(idx_q)); // R3

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_on && io_wr && io_addr == WIN_BASE) |=> (idx_q == $past(io_wdata))); // R4

    AST_IDLE_BUS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ack |-> (io_rdata == 8'hFF)); // R5

    AST_FOREIGN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd || io_wr) && io_addr != WIN_BASE && io_addr != DATA_ADDR) |=> !io_ack); // R9

endmodule

bind idxcfg_port idxcfg_port_chk #(
    .IO_ADDR_W (IO_ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .CFG_OFF_W (CFG_OFF_W),
    .EN_OFFSET (EN_OFFSET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_off  (cfg_off),
    .en_bit   (cfg_wdata[EN_BIT]),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .io_ack   (io_ack),
    .win_on   (win_on),
    .idx_q    (idx_q)
);

// File: tb/idxcfg_port_test.sv
module idxcfg_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_off = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_ack;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] model [256];

    localparam logic [15:0] A_IDX = 16'h03F0;
    localparam logic [15:0] A_DAT = 16'h03F1;

    always #10 clk = ~clk; // 50 MHz

    idxcfg_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_off   (cfg_off),
        .cfg_wdata (cfg_wdata),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .io_ack    (io_ack)
    );

    // expected defaults, from R1
    function automatic logic [7:0] dflt(input int i);
        if (i == 'hE0) return 8'h3C;
        if (i == 'hE2) return 8'h03;
        if (i == 'hE3) return 8'hFC;
        if (i == 'hE6) return 8'hDE;
        if (i == 'hE7) return 8'hFE;
        if (i == 'hE8) return 8'hBE;
        return 8'h00;
    endfunction

    // expected acceptance, from R6/R7/R8
    function automatic bit accepts(input int i, input logic [7:0] d);
        if (i == 'hE7) return d == 8'hFE;
        if (i == 'hE8) return d == 8'hBE;
        return (i >= 'hE0 && i <= 'hE3) || i == 'hE6 || (i >= 'hEE && i <= 'hF2)
            || i == 'hF4 || i == 'hF6 || i == 'hF8 || i == 'hFC;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic bus(input logic [15:0] a, input bit w, input logic [7:0] d,
                       output logic ack, output logic [7:0] q);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = !w; io_wdata = d;
        @(negedge clk);
        ack = io_ack; q = io_rdata;
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] q;
        for (int i = 0; i < 256; i++) model[i] = dflt(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ack", {7'd0, io_ack}, 8'h00);
        chk("R1 reset rdata", io_rdata, 8'hFF);

        // closed window: nothing decodes
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R3 closed read ack", {7'd0, ack}, 8'h00);
        chk("R3 closed read data", q, 8'hFF);
        bus(A_IDX, 1'b1, 8'hE1, ack, q);
        chk("R3 closed idx write ack", {7'd0, ack}, 8'h00);
        bus(A_DAT, 1'b1, 8'h77, ack, q);

        // wrong offset and clear bit keep it closed
        host_wr(8'h84, 8'h02);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R2 other offset stays closed", {7'd0, ack}, 8'h00);
        host_wr(8'h85, 8'hFD);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R2 bit1 clear stays closed", {7'd0, ack}, 8'h00);

        host_wr(8'h85, 8'h02);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R2 open ack", {7'd0, ack}, 8'h01);
        chk("R1 reset index 00 reads 00", q, 8'h00);

        // default sweep, alternating read address
        for (int i = 0; i < 256; i++) begin
            bus(A_IDX, 1'b1, 8'(i), ack, q);
            chk("R4 index write ack", {7'd0, ack}, 8'h01);
            chk("R5 write rdata idle", q, 8'hFF);
            bus((i % 2) ? A_IDX : A_DAT, 1'b0, 8'h00, ack, q);
            chk("R5 read ack", {7'd0, ack}, 8'h01);
            chk("R1 default value", q, model[i]);
        end

        // two write sweeps with different patterns
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 256; i++) begin
                logic [7:0] d;
                d = (p == 0) ? (8'(i) ^ 8'hA5) : ~8'(i);
                bus(A_IDX, 1'b1, 8'(i), ack, q);
                bus(A_DAT, 1'b1, d, ack, q);
                chk("R5 data write ack", {7'd0, ack}, 8'h01);
                if (accepts(i, d)) model[i] = d;
                bus(A_DAT, 1'b0, 8'h00, ack, q);
                if (i >= 'hE0 && accepts(i, 8'h00) && !(i == 'hE7 || i == 'hE8))
                    chk("R8 free index stores", q, model[i]);
                else if (i == 'hE7 || i == 'hE8)
                    chk("R7 locked index wrong value", q, model[i]);
                else
                    chk("R6 protected index unchanged", q, model[i]);
            end
        end

        // value-locked entries accept their one byte
        bus(A_IDX, 1'b1, 8'hE8, ack, q);
        bus(A_DAT, 1'b1, 8'hBE, ack, q);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R7 E8 accepts BE", q, 8'hBE);
        bus(A_DAT, 1'b1, 8'hBF, ack, q);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R7 E8 rejects BF", q, 8'hBE);
        bus(A_IDX, 1'b1, 8'hE7, ack, q);
        bus(A_DAT, 1'b1, 8'hFE, ack, q);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R7 E7 accepts FE", q, 8'hFE);

        // foreign addresses
        bus(A_IDX, 1'b1, 8'hE1, ack, q);
        bus(16'h03F2, 1'b1, 8'h00, ack, q);
        chk("R9 foreign write ack", {7'd0, ack}, 8'h00);
        bus(16'h02F1, 1'b1, 8'h12, ack, q);
        chk("R9 alias write ack", {7'd0, ack}, 8'h00);
        bus(16'h13F0, 1'b0, 8'h00, ack, q);
        chk("R9 foreign read ack", {7'd0, ack}, 8'h00);
        chk("R9 foreign read data", q, 8'hFF);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R9 index and reg unchanged", q, model['hE1]);

        // close, try to disturb, reopen
        host_wr(8'h85, 8'h00);
        bus(A_IDX, 1'b1, 8'hF0, ack, q);
        chk("R3 closed index write ack", {7'd0, ack}, 8'h00);
        bus(A_DAT, 1'b1, 8'h5A, ack, q);
        chk("R3 closed data write ack", {7'd0, ack}, 8'h00);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R3 closed read data", q, 8'hFF);
        host_wr(8'h10, 8'h02);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R2 other offset no open", {7'd0, ack}, 8'h00);
        host_wr(8'h85, 8'hFF);
        bus(A_DAT, 1'b0, 8'h00, ack, q);
        chk("R2 reopen ack", {7'd0, ack}, 8'h01);
        chk("R3 index and reg held while closed", q, model['hE1]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule